// File: doc/BRIEF.md
# Interrupt Presentation Controller

This unit sits between the interrupt sources of a system and one processor. It holds at most one pending interrupt and drives a single interrupt line to that processor. Sources offer interrupts as a source number, a priority and an origin tag. The unit either latches an offer, or hands it straight back to its origin on a reject pulse. A latched offer that is displaced by a more favoured one is handed back the same way.

The processor drives the unit through one-cycle strobes. It can write its current priority, write a priority for a software-generated inter-processor interrupt (IPI), accept the pending interrupt, signal end of service, and poll. Priority changes and end-of-service can clear the pending interrupt, inject the IPI (reserved source number 2), or ask every source to offer again through a resend pulse. End-of-service also forwards the serviced source number to the sources as a pulse. A lower priority value is more favoured, and 0xFF means "none".

Top module: `ipu_presenter`

## Requirements
- R1: After reset the status word is 0, the pending priority is 0xFF, the IPI priority is 0xFF, the interrupt line is low, and no pulse output is high.
- R2: The status word carries the current priority in bits 31:24 and the pending source number in bits 23:0. The interrupt line is high exactly when bits 23:0 are non-zero.
- R3: An offer is rejected when its priority is greater than or equal to the current priority. It is also rejected when an interrupt is pending whose pending priority is less than or equal to the offer's priority. A rejected offer produces a reject pulse carrying that offer's source number and origin, and the status word does not change.
- R4: An offer that is not rejected is latched with its source number, priority and origin, and it raises the interrupt line. If it displaces a pending interrupt that has an origin, that interrupt is rejected back to its own origin in the same pulse.
- R5: Writing the IPI priority stores it. When the new value is below the current priority, and no interrupt with a pending priority less than or equal to the new value is pending, source 2 is loaded with the IPI priority and no origin, and the line is raised. A displaced pending interrupt that has an origin is rejected.
- R6: Writing a current priority below the previous one clears a pending interrupt whose pending priority is greater than or equal to the new value. Clearing lowers the line, sets the pending priority to 0xFF, and rejects the interrupt to its origin if it has one.
- R7: Writing a current priority greater than or equal to the previous one, while nothing is pending, emits a resend pulse. It first injects the IPI if the IPI priority is below the new current priority.
- R8: Accept returns the status word as it was before the operation, lowers the line, moves the pending priority into bits 31:24, clears bits 23:0, and sets the pending priority to 0xFF.
- R9: End-of-service loads the current priority from bits 31:24 of the written word and emits an end-of-service pulse with bits 23:0. If nothing is pending it also performs the IPI check of R7 and emits a resend pulse.
- R10: Poll returns the status word and the IPI priority and changes no state.
- R11: At most one of the processor strobes and the offer input is active in a cycle. Every result, including reject, resend, end-of-service and read pulses, appears on the cycle after the strobe and lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| prio_we | input | 1 | Strobe: write current priority |
| prio_wdata | input | 8 | New current priority |
| ipi_we | input | 1 | Strobe: write IPI priority |
| ipi_wdata | input | 8 | New IPI priority |
| accept_req | input | 1 | Strobe: accept pending interrupt |
| eoi_we | input | 1 | Strobe: end of service |
| eoi_wdata | input | 32 | Priority to restore (31:24) and serviced source (23:0) |
| poll_req | input | 1 | Strobe: read status without side effects |
| offer_valid | input | 1 | Source offers an interrupt |
| offer_src | input | 24 | Offered source number |
| offer_prio | input | 8 | Offered priority |
| offer_org | input | ORG_W | Origin tag of the offer |
| irq_out | output | 1 | Interrupt line to the processor |
| status_word | output | 32 | Live status word |
| rd_valid | output | 1 | Read result valid (after accept or poll) |
| rd_word | output | 32 | Status word returned by accept or poll |
| rd_ipi | output | 8 | IPI priority returned by accept or poll |
| reject_valid | output | 1 | Reject pulse |
| reject_src | output | 24 | Source number handed back |
| reject_org | output | ORG_W | Origin the reject is addressed to |
| resend_req | output | 1 | Ask all sources to offer again |
| eoi_valid | output | 1 | End-of-service notice to sources |
| eoi_src | output | 24 | Source number the notice refers to |

## Verification
Every result of this block is registered once, so the status word, the interrupt line, the read port and all pulses are due one clock after the strobe that causes them. The bench drives each strobe at a falling edge and holds it across exactly one rising edge. It then samples every output at the following falling edge, where both the pulses and the new state are visible. The next strobe is applied there too, so consecutive operations also check that a pulse lasts a single cycle. The read result of an accept is compared with the status word expected before that accept, not after it.

// File: rtl/ipu_pkg.sv
// Package: shared widths and constants for the interrupt presentation unit.
// Assumes: status word layout is fixed at priority over source number.
package ipu_pkg;
    localparam int PRIO_W = 8;
    localparam int SRC_W  = 24;
    localparam int WORD_W = PRIO_W + SRC_W;

    typedef logic [PRIO_W-1:0] prio_t;
    typedef logic [SRC_W-1:0]  src_t;

    localparam prio_t PRIO_NONE = '1;
    localparam src_t  SRC_IDLE  = '0;
endpackage

// File: rtl/ipu_offer_judge.sv
// Module: decides whether an incoming offer can be latched.
// Assumes: lower numeric priority is more favoured.
module ipu_offer_judge
    import ipu_pkg::*;
(
    input  prio_t cur_prio,
    input  prio_t pend_prio,
    input  logic  pend_busy,
    input  prio_t offer_prio,
    output logic  take
);
    // Offer wins only if it beats both the processor and any pending one.
    always_comb begin
        take = (offer_prio < cur_prio) && !(pend_busy && (pend_prio <= offer_prio));
    end
endmodule

// File: rtl/ipu_ipi_judge.sv
// Module: decides whether the IPI must be injected in the present cycle.
// Assumes: caller supplies the priorities in force after the operation.
module ipu_ipi_judge
    import ipu_pkg::*;
(
    input  logic  armed,
    input  prio_t eff_cur,
    input  prio_t eff_ipi,
    input  logic  pend_busy,
    input  prio_t pend_prio,
    output logic  take
);
    // IPI enters when it beats the processor and the pending interrupt.
    always_comb begin
        take = armed && (eff_ipi < eff_cur) && !(pend_busy && (pend_prio <= eff_ipi));
    end
endmodule

// File: rtl/ipu_read_port.sv
// Module: registers the word and IPI priority returned by accept or poll.
// Assumes: capture strobe is a single cycle.
module ipu_read_port
    import ipu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [WORD_W-1:0] word_in,
    input  prio_t             ipi_in,
    output logic              rd_valid,
    output logic [WORD_W-1:0] rd_word,
    output prio_t             rd_ipi
);
    // Hold the pre-operation snapshot for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_word  <= '0;
            rd_ipi   <= PRIO_NONE;
        end else begin
            rd_valid <= capture;
            if (capture) begin
                rd_word <= word_in;
                rd_ipi  <= ipi_in;
            end
        end
    end
endmodule

// File: rtl/ipu_presenter.sv
// Module: per-processor interrupt presentation unit. Holds one pending
// interrupt, arbitrates offers, injects the IPI and emits reject, resend
// and end-of-service pulses.
// Assumes: at most one strobe or offer per cycle; all results registered.
module ipu_presenter
    import ipu_pkg::*;
#(
    parameter int ORG_W   = 4,
    parameter int IPI_SRC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prio_we,
    input  logic [7:0]        prio_wdata,
    input  logic              ipi_we,
    input  logic [7:0]        ipi_wdata,
    input  logic              accept_req,
    input  logic              eoi_we,
    input  logic [31:0]       eoi_wdata,
    input  logic              poll_req,
    input  logic              offer_valid,
    input  logic [23:0]       offer_src,
    input  logic [7:0]        offer_prio,
    input  logic [ORG_W-1:0]  offer_org,
    output logic              irq_out,
    output logic [31:0]       status_word,
    output logic              rd_valid,
    output logic [31:0]       rd_word,
    output logic [7:0]        rd_ipi,
    output logic              reject_valid,
    output logic [23:0]       reject_src,
    output logic [ORG_W-1:0]  reject_org,
    output logic              resend_req,
    output logic              eoi_valid,
    output logic [23:0]       eoi_src
);
    localparam src_t IPI_NUM = src_t'(IPI_SRC);

    prio_t            cur_q, pend_q, ipi_q;
    src_t             src_q;
    logic [ORG_W-1:0] org_q;
    logic             org_v_q, irq_q;

    prio_t            cur_d, pend_d, ipi_d;
    src_t             src_d;
    logic [ORG_W-1:0] org_d;
    logic             org_v_d, irq_d;

    logic             rej_d, res_d, eoi_d;
    src_t             rej_src_d, eoi_src_d;
    logic [ORG_W-1:0] rej_org_d;

    logic             busy, offer_take, ipi_take, ipi_armed;
    prio_t            ipi_cur, ipi_new;
    prio_t            eoi_prio;

    assign busy     = (src_q != SRC_IDLE);
    assign eoi_prio = eoi_wdata[31:24];

    // Priorities in force for the IPI check of this cycle's operation.
    always_comb begin
        ipi_cur   = prio_we ? prio_wdata : (eoi_we ? eoi_prio : cur_q);
        ipi_new   = ipi_we ? ipi_wdata : ipi_q;
        ipi_armed = ipi_we
                 || (prio_we && (prio_wdata >= cur_q) && !busy)
                 || (eoi_we && !busy);
    end

    ipu_offer_judge u_offer (
        .cur_prio  (cur_q),
        .pend_prio (pend_q),
        .pend_busy (busy),
        .offer_prio(offer_prio),
        .take      (offer_take)
    );

    ipu_ipi_judge u_ipi (
        .armed     (ipi_armed),
        .eff_cur   (ipi_cur),
        .eff_ipi   (ipi_new),
        .pend_busy (busy),
        .pend_prio (pend_q),
        .take      (ipi_take)
    );

    ipu_read_port u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (accept_req || poll_req),
        .word_in ({cur_q, src_q}),
        .ipi_in  (ipi_q),
        .rd_valid(rd_valid),
        .rd_word (rd_word),
        .rd_ipi  (rd_ipi)
    );

    // Next-state and pulse computation for the single active operation.
    always_comb begin
        cur_d     = cur_q;
        pend_d    = pend_q;
        ipi_d     = ipi_q;
        src_d     = src_q;
        org_d     = org_q;
        org_v_d   = org_v_q;
        irq_d     = irq_q;
        rej_d     = 1'b0;
        rej_src_d = src_q;
        rej_org_d = org_q;
        res_d     = 1'b0;
        eoi_d     = 1'b0;
        eoi_src_d = '0;

        if (prio_we) begin
            cur_d = prio_wdata;
            if (prio_wdata < cur_q) begin
                if (busy && (prio_wdata <= pend_q)) begin
                    src_d   = SRC_IDLE;
                    pend_d  = PRIO_NONE;
                    irq_d   = 1'b0;
                    rej_d   = org_v_q;
                    org_v_d = 1'b0;
                end
            end else if (!busy) begin
                res_d = 1'b1;
            end
        end else if (ipi_we) begin
            ipi_d = ipi_wdata;
        end else if (accept_req) begin
            cur_d   = pend_q;
            src_d   = SRC_IDLE;
            pend_d  = PRIO_NONE;
            org_v_d = 1'b0;
            irq_d   = 1'b0;
        end else if (eoi_we) begin
            cur_d     = eoi_prio;
            eoi_d     = 1'b1;
            eoi_src_d = eoi_wdata[23:0];
            res_d     = !busy;
        end else if (offer_valid) begin
            if (!offer_take) begin
                rej_d     = 1'b1;
                rej_src_d = offer_src;
                rej_org_d = offer_org;
            end else begin
                rej_d   = busy && org_v_q;
                src_d   = offer_src;
                pend_d  = offer_prio;
                org_d   = offer_org;
                org_v_d = 1'b1;
                irq_d   = 1'b1;
            end
        end

        if (ipi_take) begin
            rej_d   = busy && org_v_q;
            src_d   = IPI_NUM;
            pend_d  = ipi_new;
            org_v_d = 1'b0;
            irq_d   = 1'b1;
        end
    end

    // State and pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q        <= '0;
            pend_q       <= PRIO_NONE;
            ipi_q        <= PRIO_NONE;
            src_q        <= SRC_IDLE;
            org_q        <= '0;
            org_v_q      <= 1'b0;
            irq_q        <= 1'b0;
            reject_valid <= 1'b0;
            reject_src   <= '0;
            reject_org   <= '0;
            resend_req   <= 1'b0;
            eoi_valid    <= 1'b0;
            eoi_src      <= '0;
        end else begin
            cur_q        <= cur_d;
            pend_q       <= pend_d;
            ipi_q        <= ipi_d;
            src_q        <= src_d;
            org_q        <= org_d;
            org_v_q      <= org_v_d;
            irq_q        <= irq_d;
            reject_valid <= rej_d;
            reject_src   <= rej_d ? rej_src_d : '0;
            reject_org   <= rej_d ? rej_org_d : '0;
            resend_req   <= res_d;
            eoi_valid    <= eoi_d;
            eoi_src      <= eoi_src_d;
        end
    end

    assign irq_out     = irq_q;
    assign status_word = {cur_q, src_q};
endmodule

// File: rtl/ipu_presenter_chk.sv
// Module: property checker for the presentation unit, bound to the top.
// Assumes: observes ports only.
module ipu_presenter_chk #(
    parameter int ORG_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             prio_we,
    input logic             ipi_we,
    input logic             accept_req,
    input logic             eoi_we,
    input logic [31:0]      eoi_wdata,
    input logic             poll_req,
    input logic             offer_valid,
    input logic [23:0]      offer_src,
    input logic [7:0]       offer_prio,
    input logic             irq_out,
    input logic [31:0]      status_word,
    input logic             reject_valid,
    input logic [23:0]      reject_src,
    input logic             resend_req,
    input logic             eoi_valid,
    input logic [23:0]      eoi_src
);
    logic solo_offer;
    assign solo_offer = offer_valid && !(prio_we || ipi_we || accept_req || eoi_we || poll_req);

    AST_ONE_OP: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({prio_we, ipi_we, accept_req, eoi_we, poll_req, offer_valid}) <= 1); // R11

    AST_LINE_TRACKS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out == (status_word[23:0] != 24'd0)); // R2

    AST_WEAK_OFFER_BOUNCES: assert property (@(posedge clk) disable iff (!rst_n)
        (solo_offer && (offer_prio >= status_word[31:24]))
        |=> (reject_valid && reject_src == $past(offer_src) && $stable(status_word))); // R3

    AST_REJECT_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        reject_valid |-> $past(offer_valid || prio_we || ipi_we)); // R4

    AST_ACCEPT_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        accept_req |=> (!irq_out && status_word[23:0] == 24'd0)); // R8

    AST_EOI_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_we |=> (eoi_valid && eoi_src == $past(eoi_wdata[23:0])
                    && status_word[31:24] == $past(eoi_wdata[31:24]))); // R9

    AST_RESEND_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        resend_req |-> $past(prio_we || eoi_we)); // R7

    AST_POLL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        poll_req |=> ($stable(status_word) && !reject_valid && !resend_req)); // R10
endmodule

bind ipu_presenter ipu_presenter_chk #(.ORG_W(ORG_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .prio_we     (prio_we),
    .ipi_we      (ipi_we),
    .accept_req  (accept_req),
    .eoi_we      (eoi_we),
    .eoi_wdata   (eoi_wdata),
    .poll_req    (poll_req),
    .offer_valid (offer_valid),
    .offer_src   (offer_src),
    .offer_prio  (offer_prio),
    .irq_out     (irq_out),
    .status_word (status_word),
    .reject_valid(reject_valid),
    .reject_src  (reject_src),
    .resend_req  (resend_req),
    .eoi_valid   (eoi_valid),
    .eoi_src     (eoi_src)
);

// File: tb/ipu_presenter_tb.sv
module ipu_presenter_tb;
    localparam int ORG_W = 4;
    localparam time CLK_HALF = 10ns;

    localparam logic [2:0] OP_PRIO = 3'd0, OP_IPI = 3'd1, OP_ACC = 3'd2,
                           OP_EOI = 3'd3, OP_POLL = 3'd4, OP_OFFER = 3'd5;

    typedef struct packed {
        logic [2:0]  op;
        logic [31:0] d;      // offer: prio in 31:24, src in 23:0
        logic [3:0]  org;
        logic [31:0] e_stat;
        logic        e_irq;
        logic        e_rej;
        logic [23:0] e_rsrc;
        logic [3:0]  e_rorg;
        logic        e_res;
        logic        e_eoi;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t VEC [NV] = '{
        '{OP_PRIO,  32'h000000FF, 4'd0,  32'hFF000000, 1'b0, 1'b0, 24'h0,  4'd0,  1'b1, 1'b0}, // R7
        '{OP_OFFER, 32'h05000010, 4'd1,  32'hFF000010, 1'b1, 1'b0, 24'h0,  4'd0,  1'b0, 1'b0}, // R4
        '{OP_OFFER, 32'h07000020, 4'd2,  32'hFF000010, 1'b1, 1'b1, 24'h20, 4'd2,  1'b0, 1'b0}, // R3
        '{OP_OFFER, 32'h03000030, 4'd3,  32'hFF000030, 1'b1, 1'b1, 24'h10, 4'd1,  1'b0, 1'b0}, // R4
        '{OP_IPI,   32'h00000004, 4'd0,  32'hFF000030, 1'b1, 1'b0, 24'h0,  4'd0,  1'b0, 1'b0}, // R5
        '{OP_IPI,   32'h00000001, 4'd0,  32'hFF000002, 1'b1, 1'b1, 24'h30, 4'd3,  1'b0, 1'b0}, // R5
        '{OP_ACC,   32'h0,        4'd0,  32'h01000000, 1'b0, 1'b0, 24'h0,  4'd0,  1'b0, 1'b0}, // R8
        '{OP_OFFER, 32'h01000040, 4'd5,  32'h01000000, 1'b0, 1'b1, 24'h40, 4'd5,  1'b0, 1'b0}, // R3
        '{OP_EOI,   32'hFF000002, 4'd0,  32'hFF000002, 1'b1, 1'b0, 24'h0,  4'd0,  1'b1, 1'b1}, // R9
        '{OP_PRIO,  32'h00000000, 4'd0,  32'h00000000, 1'b0, 1'b0, 24'h0,  4'd0,  1'b0, 1'b0}, // R6
        '{OP_IPI,   32'h000000FF, 4'd0,  32'h00000000, 1'b0, 1'b0, 24'h0,  4'd0,  1'b0, 1'b0}, // R5
        '{OP_PRIO,  32'h00000080, 4'd0,  32'h80000000, 1'b0, 1'b0, 24'h0,  4'd0,  1'b1, 1'b0}, // R7
        '{OP_OFFER, 32'h10000055, 4'd6,  32'h80000055, 1'b1, 1'b0, 24'h0,  4'd0,  1'b0, 1'b0}, // R4
        '{OP_POLL,  32'h0,        4'd0,  32'h80000055, 1'b1, 1'b0, 24'h0,  4'd0,  1'b0, 1'b0}, // R10
        '{OP_PRIO,  32'h00000090, 4'd0,  32'h90000055, 1'b1, 1'b0, 24'h0,  4'd0,  1'b0, 1'b0}, // R7
        '{OP_PRIO,  32'h00000010, 4'd0,  32'h10000000, 1'b0, 1'b1, 24'h55, 4'd6,  1'b0, 1'b0}, // R6
        '{OP_OFFER, 32'h0F000066, 4'd7,  32'h10000066, 1'b1, 1'b0, 24'h0,  4'd0,  1'b0, 1'b0}, // R4
        '{OP_EOI,   32'h20000003, 4'd0,  32'h20000066, 1'b1, 1'b0, 24'h0,  4'd0,  1'b0, 1'b1}, // R9
        '{OP_ACC,   32'h0,        4'd0,  32'h0F000000, 1'b0, 1'b0, 24'h0,  4'd0,  1'b0, 1'b0}, // R8
        '{OP_PRIO,  32'h000000FF, 4'd0,  32'hFF000000, 1'b0, 1'b0, 24'h0,  4'd0,  1'b1, 1'b0}, // R7
        '{OP_OFFER, 32'hFF000077, 4'd8,  32'hFF000000, 1'b0, 1'b1, 24'h77, 4'd8,  1'b0, 1'b0}, // R3
        '{OP_OFFER, 32'h20000078, 4'd9,  32'hFF000078, 1'b1, 1'b0, 24'h0,  4'd0,  1'b0, 1'b0}, // R4
        '{OP_OFFER, 32'h20000079, 4'd10, 32'hFF000078, 1'b1, 1'b1, 24'h79, 4'd10, 1'b0, 1'b0}  // R3
    };

    logic             clk = 1'b0, rst_n = 1'b0;
    logic             prio_we = 0, ipi_we = 0, accept_req = 0, eoi_we = 0, poll_req = 0, offer_valid = 0;
    logic [7:0]       prio_wdata = 0, ipi_wdata = 0, offer_prio = 0;
    logic [31:0]      eoi_wdata = 0;
    logic [23:0]      offer_src = 0;
    logic [ORG_W-1:0] offer_org = 0;
    logic             irq_out, rd_valid, reject_valid, resend_req, eoi_valid;
    logic [31:0]      status_word, rd_word;
    logic [7:0]       rd_ipi;
    logic [23:0]      reject_src, eoi_src;
    logic [ORG_W-1:0] reject_org;

    int checks = 0, failures = 0;
    bit done = 0;

    always #CLK_HALF clk = ~clk;

    ipu_presenter #(.ORG_W(ORG_W), .IPI_SRC(2)) u_dut (.*);

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        prio_we = 0; ipi_we = 0; accept_req = 0; eoi_we = 0; poll_req = 0; offer_valid = 0;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        idle_inputs();
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] prev_stat;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(status_word == 32'h0, "R1", "status", status_word, 32'h0);
        chk(irq_out == 1'b0, "R1", "irq", {31'b0, irq_out}, 32'h0);
        chk(!reject_valid && !resend_req && !eoi_valid && !rd_valid, "R1", "pulses",
            {28'b0, reject_valid, resend_req, eoi_valid, rd_valid}, 32'h0);
        poll_req = 1; step();
        chk(rd_valid && rd_ipi == 8'hFF, "R1", "ipi after reset", {24'b0, rd_ipi}, 32'hFF);
        chk(rd_word == 32'h0, "R10", "poll word", rd_word, 32'h0);

        prev_stat = status_word;
        for (int i = 0; i < NV; i++) begin
            case (VEC[i].op)
                OP_PRIO:  begin prio_we = 1; prio_wdata = VEC[i].d[7:0]; end
                OP_IPI:   begin ipi_we = 1; ipi_wdata = VEC[i].d[7:0]; end
                OP_ACC:   accept_req = 1;
                OP_EOI:   begin eoi_we = 1; eoi_wdata = VEC[i].d; end
                OP_POLL:  poll_req = 1;
                default:  begin offer_valid = 1; offer_prio = VEC[i].d[31:24];
                                offer_src = VEC[i].d[23:0]; offer_org = VEC[i].org; end
            endcase
            step();
            // R2 R11 every result due one cycle after the strobe
            chk(status_word == VEC[i].e_stat, "R2", $sformatf("row%0d status", i), status_word, VEC[i].e_stat);
            chk(irq_out == VEC[i].e_irq, "R2", $sformatf("row%0d irq", i), {31'b0, irq_out}, {31'b0, VEC[i].e_irq});
            chk(reject_valid == VEC[i].e_rej, "R3", $sformatf("row%0d reject", i),
                {31'b0, reject_valid}, {31'b0, VEC[i].e_rej});
            if (VEC[i].e_rej) begin
                chk(reject_src == VEC[i].e_rsrc && reject_org == VEC[i].e_rorg, "R4",
                    $sformatf("row%0d reject target", i), {4'b0, reject_org, reject_src},
                    {4'b0, VEC[i].e_rorg, VEC[i].e_rsrc});
            end
            chk(resend_req == VEC[i].e_res, "R7", $sformatf("row%0d resend", i),
                {31'b0, resend_req}, {31'b0, VEC[i].e_res});
            chk(eoi_valid == VEC[i].e_eoi, "R9", $sformatf("row%0d eoi", i),
                {31'b0, eoi_valid}, {31'b0, VEC[i].e_eoi});
            if (VEC[i].e_eoi)
                chk(eoi_src == VEC[i].d[23:0], "R9", "eoi source", {8'b0, eoi_src}, {8'b0, VEC[i].d[23:0]});
            chk(rd_valid == (VEC[i].op == OP_ACC || VEC[i].op == OP_POLL), "R11",
                $sformatf("row%0d rd_valid", i), {31'b0, rd_valid}, 32'h0);
            if (VEC[i].op == OP_ACC || VEC[i].op == OP_POLL)
                chk(rd_word == prev_stat, "R8", $sformatf("row%0d read word", i), rd_word, prev_stat);
            prev_stat = VEC[i].e_stat;
        end

        // R11 pulses last one cycle
        @(negedge clk);
        chk(!reject_valid && !rd_valid, "R11", "pulse width", {30'b0, reject_valid, rd_valid}, 32'h0);

        // R5 IPI priority stored but not injected behind a better pending one
        ipi_we = 1; ipi_wdata = 8'h40; step();
        chk(status_word == 32'hFF000078, "R5", "ipi blocked", status_word, 32'hFF000078);
        poll_req = 1; step();
        chk(rd_ipi == 8'h40, "R10", "ipi readback", {24'b0, rd_ipi}, 32'h40);

        // R1 reset in mid-run clears pending state
        rst_n = 0; @(posedge clk); @(negedge clk); rst_n = 1; @(negedge clk);
        chk(status_word == 32'h0 && !irq_out, "R1", "mid reset", status_word, 32'h0);
        poll_req = 1; step();
        chk(rd_ipi == 8'hFF, "R1", "ipi after mid reset", {24'b0, rd_ipi}, 32'hFF);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule